// File: doc/BRIEF.md
# Accelerator Memory Port Arbiter

This block lets a host processor and an accelerator share a single memory port. Each side offers memory requests on its own valid/ready channel. The block merges them into one request channel toward memory, and the accelerator always wins when both sides are valid. Each request carries a command, a memory-type field, a tag, an address and data.

The block records every accelerator request that memory accepts, keyed by its tag, in a small table of outstanding transactions. Writes are recorded the same way as reads, because memory answers every write with a response. Each response from memory is steered by its tag. If the tag is live in the accelerator's table, the response goes to the accelerator; otherwise it goes to the host. The response fields go out unchanged on a shared bus, and each side has its own valid and ready.

A busy flag tells the accelerator's controller that work is still in flight. It rises in the same cycle that the first accelerator request is accepted, and it stays high until the last outstanding read or write has been answered.

Top module: `mem_port_arb`

## Requirements
- R1: When the accelerator presents a valid request, the memory request fields equal the accelerator's fields, and host_req_ready is 0 in that cycle, whatever the host drives.
- R2: When the accelerator has no valid request, mem_req_valid follows host_req_valid, the memory request fields equal the host's fields, and host_req_ready equals mem_req_ready.
- R3: A request transfers only when valid and ready are both high. acc_req_ready is 0 whenever mem_req_ready is 0, and a request offered while ready is low is not recorded as outstanding.
- R4: With SLOTS accelerator transactions outstanding, acc_req_ready is 0 and mem_req_valid is 0 while the accelerator stays valid, and the host stays blocked. Once one of them retires, acc_req_ready returns in the next cycle.
- R5: A memory response whose 9-bit tag matches a live accelerator entry raises acc_rsp_valid, keeps host_rsp_valid at 0, and drives mem_rsp_ready from acc_rsp_ready. The entry is freed only on the cycle that handshake completes.
- R6: A memory response whose tag matches no live accelerator entry raises host_rsp_valid and keeps acc_rsp_valid at 0, with mem_rsp_ready taken from host_rsp_ready. No other indication is raised.
- R7: Tracking does not depend on the command. A write (cmd 1) is recorded and routed back exactly like a read (cmd 0), and after it retires the same tag routes to the host.
- R8: acc_busy is 1 in the cycle an accelerator request is accepted from an empty table. It stays 1 while any entry is live and drops in the cycle after the last entry retires.
- R9: After reset the table is empty and acc_busy is 0.
- R10: The response cmd, tag, mtype and data outputs equal the memory response fields in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_req_valid | input | 1 | Accelerator request valid |
| acc_req_ready | output | 1 | Accelerator request accepted |
| acc_req_cmd | input | 2 | Accelerator command (0 read, 1 write) |
| acc_req_mtype | input | 2 | Accelerator memory type |
| acc_req_tag | input | 9 | Accelerator tag |
| acc_req_addr | input | 64 | Accelerator address |
| acc_req_data | input | 64 | Accelerator write data |
| host_req_valid | input | 1 | Host request valid |
| host_req_ready | output | 1 | Host request accepted |
| host_req_cmd | input | 2 | Host command |
| host_req_mtype | input | 2 | Host memory type |
| host_req_tag | input | 9 | Host tag |
| host_req_addr | input | 64 | Host address |
| host_req_data | input | 64 | Host write data |
| mem_req_valid | output | 1 | Merged request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_cmd | output | 2 | Merged command |
| mem_req_mtype | output | 2 | Merged memory type |
| mem_req_tag | output | 9 | Merged tag |
| mem_req_addr | output | 64 | Merged address |
| mem_req_data | output | 64 | Merged data |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_ready | output | 1 | Response consumed by its destination |
| mem_rsp_cmd | input | 2 | Response command |
| mem_rsp_tag | input | 9 | Response tag |
| mem_rsp_mtype | input | 2 | Response memory type |
| mem_rsp_data | input | 64 | Response data |
| acc_rsp_valid | output | 1 | Response steered to accelerator |
| acc_rsp_ready | input | 1 | Accelerator takes response |
| host_rsp_valid | output | 1 | Response steered to host |
| host_rsp_ready | input | 1 | Host takes response |
| rsp_cmd | output | 2 | Shared response command |
| rsp_tag | output | 9 | Shared response tag |
| rsp_mtype | output | 2 | Shared response memory type |
| rsp_data | output | 64 | Shared response data |
| acc_busy | output | 1 | Accelerator transactions in flight |

## Verification
The bench builds the block with a four-entry outstanding table and the default field widths. The small table puts the full condition within a handful of accepted requests, so back-pressure on both request sources can be checked, followed by recovery after a single retirement. With only four entries, a write and a read can also share the table, so the bench can show that a freed tag falls back to the host and that busy falls exactly one cycle after the final response handshake.

// File: rtl/mpa_pkg.sv
package mpa_pkg;
  typedef enum logic [1:0] {
    CMD_READ  = 2'd0,
    CMD_WRITE = 2'd1
  } mpa_cmd_e;

  // isolate the lowest set bit of a mask
  function automatic logic [31:0] lowest_one(input logic [31:0] m);
    return m & (~m + 32'd1);
  endfunction

  // number of set bits in a mask
  function automatic logic [5:0] pop_count(input logic [31:0] m);
    logic [5:0] n;
    n = '0;
    for (int i = 0; i < 32; i++) n = n + {5'd0, m[i]};
    return n;
  endfunction
endpackage

// File: rtl/mpa_req_mux.sv
module mpa_req_mux #(
  parameter int REQ_W = 141
) (
  input  logic             acc_valid,
  input  logic [REQ_W-1:0] acc_bits,
  input  logic             host_valid,
  input  logic [REQ_W-1:0] host_bits,
  input  logic             acc_room,
  input  logic             mem_ready,
  output logic             mem_valid,
  output logic [REQ_W-1:0] mem_bits,
  output logic             acc_ready,
  output logic             host_ready,
  output logic             acc_take
);
  // the accelerator owns the port whenever it is valid
  assign mem_valid  = acc_valid ? acc_room : host_valid;
  assign mem_bits   = acc_valid ? acc_bits : host_bits;
  assign acc_ready  = mem_ready & acc_room;
  assign host_ready = mem_ready & ~acc_valid;
  assign acc_take   = acc_valid & acc_ready;
endmodule

// File: rtl/mpa_tag_table.sv
module mpa_tag_table
  import mpa_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int TAG_W = 9,
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic [TAG_W-1:0] lookup_tag,
  input  logic             retire_en,
  output logic             hit,
  output logic             full,
  output logic             any_live,
  output logic [CNT_W-1:0] live_count
);
  logic [SLOTS-1:0] live;
  logic [SLOTS-1:0] match;
  logic [SLOTS-1:0] alloc_oh;
  logic [SLOTS-1:0] retire_oh;
  logic [31:0]      free_low;
  logic [31:0]      match_low;
  logic [5:0]       pop;
  logic [TAG_W-1:0] tags [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    assign match[i] = live[i] && (tags[i] == lookup_tag);
    always_ff @(posedge clk) begin
      if (!rst_n)                     tags[i] <= '0;
      else if (alloc_en && alloc_oh[i]) tags[i] <= alloc_tag;
    end
  end

  assign free_low   = lowest_one(32'(~live));
  assign match_low  = lowest_one(32'(match));
  assign alloc_oh   = free_low[SLOTS-1:0];
  assign retire_oh  = match_low[SLOTS-1:0];
  assign pop        = pop_count(32'(live));
  assign live_count = pop[CNT_W-1:0];
  assign hit        = |match;
  assign full       = &live;
  assign any_live   = |live;

  always_ff @(posedge clk) begin
    if (!rst_n) live <= '0;
    else live <= (live & ~(retire_en ? retire_oh : '0)) | (alloc_en ? alloc_oh : '0);
  end
endmodule

// File: rtl/mpa_rsp_router.sv
module mpa_rsp_router (
  input  logic mem_valid,
  input  logic hit,
  input  logic acc_ready,
  input  logic host_ready,
  output logic acc_valid,
  output logic host_valid,
  output logic mem_ready,
  output logic retire
);
  assign acc_valid  = mem_valid & hit;
  assign host_valid = mem_valid & ~hit;
  assign mem_ready  = hit ? acc_ready : host_ready;
  assign retire     = acc_valid & acc_ready;
endmodule

// File: rtl/mem_port_arb.sv
module mem_port_arb #(
  parameter int CMD_W  = 2,
  parameter int TYPE_W = 2,
  parameter int TAG_W  = 9,
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64,
  parameter int SLOTS  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_req_valid,
  output logic              acc_req_ready,
  input  logic [CMD_W-1:0]  acc_req_cmd,
  input  logic [TYPE_W-1:0] acc_req_mtype,
  input  logic [TAG_W-1:0]  acc_req_tag,
  input  logic [ADDR_W-1:0] acc_req_addr,
  input  logic [DATA_W-1:0] acc_req_data,
  input  logic              host_req_valid,
  output logic              host_req_ready,
  input  logic [CMD_W-1:0]  host_req_cmd,
  input  logic [TYPE_W-1:0] host_req_mtype,
  input  logic [TAG_W-1:0]  host_req_tag,
  input  logic [ADDR_W-1:0] host_req_addr,
  input  logic [DATA_W-1:0] host_req_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [CMD_W-1:0]  mem_req_cmd,
  output logic [TYPE_W-1:0] mem_req_mtype,
  output logic [TAG_W-1:0]  mem_req_tag,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_data,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [CMD_W-1:0]  mem_rsp_cmd,
  input  logic [TAG_W-1:0]  mem_rsp_tag,
  input  logic [TYPE_W-1:0] mem_rsp_mtype,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              acc_rsp_valid,
  input  logic              acc_rsp_ready,
  output logic              host_rsp_valid,
  input  logic              host_rsp_ready,
  output logic [CMD_W-1:0]  rsp_cmd,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [TYPE_W-1:0] rsp_mtype,
  output logic [DATA_W-1:0] rsp_data,
  output logic              acc_busy
);
  localparam int REQ_W = CMD_W + TYPE_W + TAG_W + ADDR_W + DATA_W;
  localparam int CNT_W = $clog2(SLOTS + 1);

  // named internal events, observed by the bound checker
  logic             acc_take;
  logic             rsp_hit;
  logic             rsp_retire;
  logic             tbl_full;
  logic             tbl_any;
  logic [CNT_W-1:0] live_count;
  logic [REQ_W-1:0] acc_bits, host_bits, mem_bits;

  assign acc_bits  = {acc_req_cmd, acc_req_mtype, acc_req_tag, acc_req_addr, acc_req_data};
  assign host_bits = {host_req_cmd, host_req_mtype, host_req_tag, host_req_addr, host_req_data};
  assign {mem_req_cmd, mem_req_mtype, mem_req_tag, mem_req_addr, mem_req_data} = mem_bits;

  mpa_req_mux #(.REQ_W(REQ_W)) u_req_mux (
    .acc_valid  (acc_req_valid),
    .acc_bits   (acc_bits),
    .host_valid (host_req_valid),
    .host_bits  (host_bits),
    .acc_room   (~tbl_full),
    .mem_ready  (mem_req_ready),
    .mem_valid  (mem_req_valid),
    .mem_bits   (mem_bits),
    .acc_ready  (acc_req_ready),
    .host_ready (host_req_ready),
    .acc_take   (acc_take)
  );

  mpa_tag_table #(.SLOTS(SLOTS), .TAG_W(TAG_W)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_en   (acc_take),
    .alloc_tag  (acc_req_tag),
    .lookup_tag (mem_rsp_tag),
    .retire_en  (rsp_retire),
    .hit        (rsp_hit),
    .full       (tbl_full),
    .any_live   (tbl_any),
    .live_count (live_count)
  );

  mpa_rsp_router u_router (
    .mem_valid  (mem_rsp_valid),
    .hit        (rsp_hit),
    .acc_ready  (acc_rsp_ready),
    .host_ready (host_rsp_ready),
    .acc_valid  (acc_rsp_valid),
    .host_valid (host_rsp_valid),
    .mem_ready  (mem_rsp_ready),
    .retire     (rsp_retire)
  );

  assign rsp_cmd   = mem_rsp_cmd;
  assign rsp_tag   = mem_rsp_tag;
  assign rsp_mtype = mem_rsp_mtype;
  assign rsp_data  = mem_rsp_data;

  assign acc_busy = tbl_any | acc_take;
endmodule

// File: rtl/mpa_checker.sv
module mpa_checker #(
  parameter int SLOTS = 8,
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_req_valid,
  input logic             acc_req_ready,
  input logic             host_req_ready,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic             mem_rsp_valid,
  input logic             acc_rsp_valid,
  input logic             host_rsp_valid,
  input logic             acc_busy,
  input logic             acc_take,
  input logic             rsp_retire,
  input logic [CNT_W-1:0] live_count
);
  logic [CNT_W:0] shadow;
  always_ff @(posedge clk) begin
    if (!rst_n) shadow <= '0;
    else shadow <= shadow + (CNT_W+1)'(acc_take) - (CNT_W+1)'(rsp_retire);
  end

  assert_acc_priority_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req_valid |-> !host_req_ready);
  assert_ready_needs_mem_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req_ready |-> mem_req_ready);
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (live_count == CNT_W'(SLOTS)) |-> (!acc_req_ready && !(acc_req_valid && mem_req_valid)));
  assert_count_matches_R4: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, live_count} == shadow);
  assert_route_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> $onehot({acc_rsp_valid, host_rsp_valid}));
  assert_route_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rsp_valid |-> !(acc_rsp_valid || host_rsp_valid));
  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (live_count != '0) |-> acc_busy);
  assert_busy_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(acc_busy) |-> $past(rsp_retire));
endmodule

bind mem_port_arb mpa_checker #(.SLOTS(SLOTS)) u_mpa_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .acc_req_valid  (acc_req_valid),
  .acc_req_ready  (acc_req_ready),
  .host_req_ready (host_req_ready),
  .mem_req_valid  (mem_req_valid),
  .mem_req_ready  (mem_req_ready),
  .mem_rsp_valid  (mem_rsp_valid),
  .acc_rsp_valid  (acc_rsp_valid),
  .host_rsp_valid (host_rsp_valid),
  .acc_busy       (acc_busy),
  .acc_take       (acc_take),
  .rsp_retire     (rsp_retire),
  .live_count     (live_count)
);

// File: tb/mem_port_arb_bench.sv
module mem_port_arb_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 4;

  logic clk = 0, rst_n = 0;
  logic acc_req_valid = 0, host_req_valid = 0, mem_req_ready = 0;
  logic [1:0] acc_req_cmd = 0, acc_req_mtype = 0, host_req_cmd = 0, host_req_mtype = 0;
  logic [8:0] acc_req_tag = 0, host_req_tag = 0;
  logic [63:0] acc_req_addr = 0, acc_req_data = 0, host_req_addr = 0, host_req_data = 0;
  logic mem_rsp_valid = 0, acc_rsp_ready = 0, host_rsp_ready = 0;
  logic [1:0] mem_rsp_cmd = 0, mem_rsp_mtype = 0;
  logic [8:0] mem_rsp_tag = 0;
  logic [63:0] mem_rsp_data = 0;
  logic acc_req_ready, host_req_ready, mem_req_valid, mem_rsp_ready;
  logic [1:0] mem_req_cmd, mem_req_mtype, rsp_cmd, rsp_mtype;
  logic [8:0] mem_req_tag, rsp_tag;
  logic [63:0] mem_req_addr, mem_req_data, rsp_data;
  logic acc_rsp_valid, host_rsp_valid, acc_busy;

  int total = 0, bad = 0;
  bit finished = 0;

  mem_port_arb #(.SLOTS(SLOTS)) u_mem_port_arb (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input logic [63:0] act, input logic [63:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  // advance one edge and land just after the following falling edge
  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic rsp(input logic [8:0] tag, input logic [1:0] cmd, input logic [63:0] d);
    mem_rsp_valid = 1; mem_rsp_tag = tag; mem_rsp_cmd = cmd; mem_rsp_mtype = 2'd2; mem_rsp_data = d;
  endtask

  task automatic t_reset();
    #1;
    eq("R9 busy after reset", acc_busy, 0);
    eq("R9 acc ready with empty table", acc_req_ready, 0);
    mem_req_ready = 1; #1;
    eq("R9 acc ready once mem ready", acc_req_ready, 1);
    eq("R9 no request", mem_req_valid, 0);
  endtask

  task automatic t_host_only();
    host_req_valid = 1; host_req_addr = 64'h1000; host_req_tag = 9'd3; host_req_cmd = 0; #1;
    eq("R2 mem valid from host", mem_req_valid, 1);
    eq("R2 host addr", mem_req_addr, 64'h1000);
    eq("R2 host ready", host_req_ready, 1);
    eq("R2 busy stays low", acc_busy, 0);
    mem_req_ready = 0; #1;
    eq("R3 host ready follows mem", host_req_ready, 0);
    step();
    mem_req_ready = 1; host_req_valid = 0; #1;
  endtask

  task automatic t_priority();
    mem_req_ready = 0;
    acc_req_valid = 1; acc_req_tag = 9'd5; acc_req_cmd = 0; acc_req_addr = 64'hA000; acc_req_data = 64'h11;
    host_req_valid = 1; #1;
    eq("R3 acc ready low without mem ready", acc_req_ready, 0);
    eq("R3 busy low when nothing accepted", acc_busy, 0);
    step();
    eq("R3 nothing recorded", acc_busy, 0);
    mem_req_ready = 1; #1;
    eq("R1 acc addr wins", mem_req_addr, 64'hA000);
    eq("R1 acc tag wins", mem_req_tag, 9'd5);
    eq("R1 host blocked", host_req_ready, 0);
    eq("R8 busy same cycle", acc_busy, 1);
    step();
    acc_req_valid = 1; acc_req_tag = 9'd9; acc_req_cmd = 1; acc_req_addr = 64'hB000; #1;
    eq("R7 write passes as acc", mem_req_cmd, 1);
    step();
    acc_req_valid = 0; host_req_valid = 0; #1;
    eq("R8 busy held", acc_busy, 1);
  endtask

  task automatic t_routes();
    host_rsp_ready = 0; acc_rsp_ready = 1;
    rsp(9'd77, 0, 64'hDEAD); #1;
    eq("R6 unknown to host", host_rsp_valid, 1);
    eq("R6 not to acc", acc_rsp_valid, 0);
    eq("R6 ready from host", mem_rsp_ready, 0);
    eq("R10 data unchanged", rsp_data, 64'hDEAD);
    eq("R10 tag unchanged", rsp_tag, 9'd77);
    eq("R10 mtype unchanged", rsp_mtype, 2'd2);
    host_rsp_ready = 1; #1;
    eq("R6 ready from host", mem_rsp_ready, 1);
    step();
    acc_rsp_ready = 0; rsp(9'd9, 1, 64'h22); #1;
    eq("R7 write rsp to acc", acc_rsp_valid, 1);
    eq("R5 host idle", host_rsp_valid, 0);
    eq("R5 ready from acc", mem_rsp_ready, 0);
    step();
    eq("R5 no retire without ready", acc_rsp_valid, 1);
    acc_rsp_ready = 1; #1;
    eq("R5 ready from acc", mem_rsp_ready, 1);
    step();
    eq("R7 freed tag goes to host", host_rsp_valid, 1);
    eq("R8 busy with read left", acc_busy, 1);
    rsp(9'd5, 0, 64'h33); #1;
    eq("R5 read rsp to acc", acc_rsp_valid, 1);
    eq("R10 cmd unchanged", rsp_cmd, 0);
    step();
    mem_rsp_valid = 0; #1;
    eq("R8 busy drops after last", acc_busy, 0);
  endtask

  task automatic t_full();
    acc_rsp_ready = 1;
    for (int i = 0; i < SLOTS; i++) begin
      acc_req_valid = 1; acc_req_tag = 9'(20 + i); acc_req_cmd = 2'(i % 2); #1;
      eq("R4 room before full", acc_req_ready, 1);
      step();
    end
    acc_req_tag = 9'd24; host_req_valid = 1; #1;
    eq("R4 acc ready low when full", acc_req_ready, 0);
    eq("R4 no mem request when full", mem_req_valid, 0);
    eq("R4 host blocked when full", host_req_ready, 0);
    rsp(9'd21, 1, 64'h44); #1;
    eq("R5 retire in full table", acc_rsp_valid, 1);
    step();
    mem_rsp_valid = 0; #1;
    eq("R4 room after one retire", acc_req_ready, 1);
    acc_req_valid = 0; host_req_valid = 0;
    rsp(9'd20, 0, 0); step();
    rsp(9'd22, 0, 0); step();
    eq("R8 busy before final", acc_busy, 1);
    rsp(9'd23, 1, 0); step();
    mem_rsp_valid = 0; #1;
    eq("R8 busy clear after drain", acc_busy, 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset();
    t_host_only();
    t_priority();
    t_routes();
    t_full();
    summary();
  end
endmodule